// File: doc/BRIEF.md
# Core Low-Power Sequencer

This block controls the clock and power state of one processor core and its private second-level cache. While the core is idle in its wait-for-interrupt state, the block gates their shared clock. The clock comes back only when an interrupt or a coherence snoop arrives, or when the block is reset. The block itself runs on the free-running clock. It drives a clock-enable bit that an external gating cell uses.

Software sets two control bits to request a power-down: one enables core power control and one asks for a cache flush for power. The block then works through a fixed order:

1. Request a cache flush and hold the request until the flush completes.
2. Wait for the core to reach wait-for-interrupt.
3. Raise a power-down request to the external power controller and hold it until that controller acknowledges.

The external controller sequences isolation, reset and supply. An interrupt or a snoop in the powered-off state starts a power-up handshake. The block returns to normal running once power-up is acknowledged.

Top module: `core_lp_seq`

## Requirements
- R1: After reset, `core_clk_en` is 1 and `flush_req`, `pd_req` and `pu_req` are all 0.
- R2: In normal running with the clock enabled, a cycle with `core_wfi`=1 and no interrupt or snoop drives `core_clk_en` to 0 at the next clock edge.
- R3: Once the clock is gated in normal running, `core_clk_en` stays 0 even if `core_wfi` falls. It returns to 1 at the next edge after any bit of `irq_vec` or `snoop_req` is 1.
- R4: With the clock enabled in normal running, `pwr_ctl_en`=1 together with `pwr_flush_cmd`=1 asserts `flush_req` at the next edge. Either bit alone has no effect, and both together have no effect while the clock is gated.
- R5: `flush_req` stays 1 until a cycle with `flush_done`=1. It falls at the next edge, and the sequencer then waits for wait-for-interrupt.
- R6: `pd_req` rises only after the flush has completed and `core_wfi` is then seen at 1. A `core_wfi` seen during the flush does not advance the sequence.
- R7: `pd_req` stays 1 until `pd_ack`=1, then falls at the next edge. `core_clk_en` is 0 from the rise of `pd_req` until power-up completes.
- R8: Any interrupt bit set while the flush or the wait-for-interrupt step is in progress returns the block to normal running at the next edge, with `core_clk_en`=1, `flush_req`=0 and no `pd_req`. A snoop does not abort the sequence.
- R9: While powered off, any interrupt bit or `snoop_req` raises `pu_req` at the next edge. `pu_req` holds until `pu_ack`=1, after which the block is in normal running with `core_clk_en`=1.
- R10: An interrupt arriving while `pd_req` is high does not withdraw it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_ctl_en | input | 1 | Software bit: core power control enabled |
| pwr_flush_cmd | input | 1 | Software bit: flush cache for power-down |
| core_wfi | input | 1 | Core is in wait-for-interrupt |
| irq_vec | input | NUM_IRQ | Pending interrupt lines |
| snoop_req | input | 1 | Incoming coherence snoop |
| flush_req | output | 1 | Cache flush request |
| flush_done | input | 1 | Cache flush complete pulse |
| pd_req | output | 1 | Power-down request to the power controller |
| pd_ack | input | 1 | Power-down acknowledge |
| pu_req | output | 1 | Power-up request to the power controller |
| pu_ack | input | 1 | Power-up acknowledge |
| core_clk_en | output | 1 | Registered clock enable for core and cache |

## Verification
The assertions assume the following about the neighbours:
- `flush_done` arrives only while a flush is requested.
- `pd_ack` arrives only while `pd_req` is high.
- `pu_ack` arrives only while `pu_req` is high.
- The software control bits are not raised while the core clock is gated.

The stimulus raises each acknowledge or done input for exactly one cycle, and only in the matching request phase. It raises an interrupt or snoop during the flush, the wait-for-interrupt step, the power-down request and the off state, to cover each wake and abort path.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;

  typedef enum logic [2:0] {
    ST_RUN      = 3'd0,
    ST_FLUSH    = 3'd1,
    ST_WAIT_WFI = 3'd2,
    ST_PD_REQ   = 3'd3,
    ST_OFF      = 3'd4,
    ST_PU_REQ   = 3'd5
  } lp_state_e;

  // States in which the core/cache clock is held off by the power sequence
  function automatic logic pwr_gated(lp_state_e s);
    return (s == ST_PD_REQ) || (s == ST_OFF) || (s == ST_PU_REQ);
  endfunction

  // States in which an interrupt still aborts the power-down sequence
  function automatic logic abortable(lp_state_e s);
    return (s == ST_FLUSH) || (s == ST_WAIT_WFI);
  endfunction

endpackage

// File: rtl/lp_wake_det.sv
module lp_wake_det #(
  parameter int NUM_IRQ = 4
) (
  input  logic [NUM_IRQ-1:0] irq_vec,
  input  logic               snoop_req,
  output logic               irq_any,
  output logic               wake_any
);
  assign irq_any  = |irq_vec;
  assign wake_any = irq_any | snoop_req;
endmodule

// File: rtl/lp_seq_fsm.sv
module lp_seq_fsm
  import lp_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_cmd,
  input  logic      clk_on,
  input  logic      irq_any,
  input  logic      wake_any,
  input  logic      flush_done,
  input  logic      core_wfi,
  input  logic      pd_ack,
  input  logic      pu_ack,
  output lp_state_e state_q,
  output lp_state_e state_n
);
  logic abort_hit;
  logic flush_go;

  assign abort_hit = abortable(state_q) && irq_any;
  assign flush_go  = (state_q == ST_RUN) && clk_on && start_cmd;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_RUN:      if (flush_go) state_n = ST_FLUSH;
      ST_FLUSH:    if (abort_hit) state_n = ST_RUN;
                   else if (flush_done) state_n = ST_WAIT_WFI;
      ST_WAIT_WFI: if (abort_hit) state_n = ST_RUN;
                   else if (core_wfi) state_n = ST_PD_REQ;
      ST_PD_REQ:   if (pd_ack) state_n = ST_OFF;
      ST_OFF:      if (wake_any) state_n = ST_PU_REQ;
      ST_PU_REQ:   if (pu_ack) state_n = ST_RUN;
      default:     state_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_n;
  end

  assert_flush_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FLUSH && !flush_done && !irq_any) |=> (state_q == ST_FLUSH));
  assert_pd_after_wfi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PD_REQ && $past(state_q) != ST_PD_REQ) |-> ($past(core_wfi) && $past(state_q) == ST_WAIT_WFI));
  assert_pd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PD_REQ && !pd_ack) |=> (state_q == ST_PD_REQ));
  assert_irq_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (abortable(state_q) && irq_any) |=> (state_q == ST_RUN));
  assert_pu_on_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OFF && wake_any) |=> (state_q == ST_PU_REQ));
endmodule

// File: rtl/lp_clk_ctl.sv
module lp_clk_ctl
  import lp_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  lp_state_e state_q,
  input  lp_state_e state_n,
  input  logic      core_wfi,
  input  logic      wake_any,
  output logic      clk_en_q
);
  logic clk_en_d;
  logic stay_run;

  assign stay_run = (state_q == ST_RUN) && (state_n == ST_RUN);

  always_comb begin
    if (pwr_gated(state_n))       clk_en_d = 1'b0;
    else if (!stay_run)           clk_en_d = 1'b1;
    else if (clk_en_q)            clk_en_d = !(core_wfi && !wake_any);
    else                          clk_en_d = wake_any;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) clk_en_q <= 1'b1;
    else        clk_en_q <= clk_en_d;
  end

  assert_gate_on_wfi_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && clk_en_q && core_wfi && !wake_any && state_n == ST_RUN) |=> !clk_en_q);
  assert_gate_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && !clk_en_q && !wake_any) |=> !clk_en_q);
  assert_gate_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && !clk_en_q && wake_any) |=> clk_en_q);
  assert_off_no_clk_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_gated(state_q) |-> !clk_en_q);
endmodule

// File: rtl/core_lp_seq.sv
module core_lp_seq
  import lp_seq_pkg::*;
#(
  parameter int NUM_IRQ = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwr_ctl_en,
  input  logic               pwr_flush_cmd,
  input  logic               core_wfi,
  input  logic [NUM_IRQ-1:0] irq_vec,
  input  logic               snoop_req,
  output logic               flush_req,
  input  logic               flush_done,
  output logic               pd_req,
  input  logic               pd_ack,
  output logic               pu_req,
  input  logic               pu_ack,
  output logic               core_clk_en
);
  logic      irq_any;
  logic      wake_any;
  logic      start_cmd;
  lp_state_e state_q;
  lp_state_e state_n;

  assign start_cmd = pwr_ctl_en & pwr_flush_cmd;

  lp_wake_det #(.NUM_IRQ(NUM_IRQ)) u_wake (
    .irq_vec  (irq_vec),
    .snoop_req(snoop_req),
    .irq_any  (irq_any),
    .wake_any (wake_any)
  );

  lp_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_cmd (start_cmd),
    .clk_on    (core_clk_en),
    .irq_any   (irq_any),
    .wake_any  (wake_any),
    .flush_done(flush_done),
    .core_wfi  (core_wfi),
    .pd_ack    (pd_ack),
    .pu_ack    (pu_ack),
    .state_q   (state_q),
    .state_n   (state_n)
  );

  lp_clk_ctl u_clk (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_q (state_q),
    .state_n (state_n),
    .core_wfi(core_wfi),
    .wake_any(wake_any),
    .clk_en_q(core_clk_en)
  );

  assign flush_req = (state_q == ST_FLUSH);
  assign pd_req    = (state_q == ST_PD_REQ);
  assign pu_req    = (state_q == ST_PU_REQ);

  assert_req_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flush_req, pd_req, pu_req}));
  assert_pd_keeps_on_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_req && !pd_ack) |=> pd_req);
  assert_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && core_clk_en && pwr_ctl_en && pwr_flush_cmd) |=> flush_req);
endmodule

// File: tb/core_lp_seq_test.sv
module core_lp_seq_test;
  localparam int NI = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_ctl_en = 1'b0, pwr_flush_cmd = 1'b0, core_wfi = 1'b0;
  logic [NI-1:0] irq_vec = '0;
  logic snoop_req = 1'b0, flush_done = 1'b0, pd_ack = 1'b0, pu_ack = 1'b0;
  logic flush_req, pd_req, pu_req, core_clk_en;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string cur_req = "R1";

  // behavioural reference: phase 0 run, 1 flushing, 2 awaiting wfi, 3 pd, 4 off, 5 pu
  int  m_phase = 0;
  bit  m_clk = 1'b1;

  always #5 clk = ~clk;

  core_lp_seq #(.NUM_IRQ(NI)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_ctl_en(pwr_ctl_en), .pwr_flush_cmd(pwr_flush_cmd),
    .core_wfi(core_wfi), .irq_vec(irq_vec), .snoop_req(snoop_req),
    .flush_req(flush_req), .flush_done(flush_done), .pd_req(pd_req), .pd_ack(pd_ack),
    .pu_req(pu_req), .pu_ack(pu_ack), .core_clk_en(core_clk_en)
  );

  always @(posedge clk) begin
    bit irq, wk;
    int np;
    bit nc;
    irq = (irq_vec != 0);
    wk  = irq || snoop_req;
    np  = m_phase;
    nc  = m_clk;
    if (!rst_n) begin
      np = 0; nc = 1'b1;
    end else if (m_phase == 0) begin
      if (m_clk && pwr_ctl_en && pwr_flush_cmd) np = 1;
      else if (m_clk && core_wfi && !wk) nc = 1'b0;
      else if (!m_clk && wk) nc = 1'b1;
    end else if (m_phase == 1) begin
      if (irq) np = 0; else if (flush_done) np = 2;
    end else if (m_phase == 2) begin
      if (irq) np = 0; else if (core_wfi) begin np = 3; nc = 1'b0; end
    end else if (m_phase == 3) begin
      if (pd_ack) np = 4;
    end else if (m_phase == 4) begin
      if (wk) np = 5;
    end else begin
      if (pu_ack) begin np = 0; nc = 1'b1; end
    end
    m_phase <= np;
    m_clk   <= nc;
  end

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // compare against the reference on every clock, 2 ns after the edge
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      check(cur_req, "model core_clk_en", core_clk_en, m_clk);
      check(cur_req, "model flush_req", flush_req, m_phase == 1);
      check(cur_req, "model pd_req", pd_req, m_phase == 3);
      check(cur_req, "model pu_req", pu_req, m_phase == 5);
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected < 5000", cycles);
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    #1;
    cur_req = "R1";
    check("R1", "reset clk_en", core_clk_en, 1'b1);
    check("R1", "reset flush_req", flush_req, 1'b0);
    check("R1", "reset pd_req", pd_req, 1'b0);
    check("R1", "reset pu_req", pu_req, 1'b0);

    cur_req = "R4";
    pwr_ctl_en = 1; tick();
    check("R4", "enable alone", flush_req, 1'b0);
    pwr_ctl_en = 0; pwr_flush_cmd = 1; tick();
    check("R4", "flush cmd alone", flush_req, 1'b0);
    pwr_ctl_en = 1; tick();
    check("R4", "both bits start", flush_req, 1'b1);
    pwr_ctl_en = 0; pwr_flush_cmd = 0;

    cur_req = "R5";
    tick(); tick();
    check("R5", "flush held", flush_req, 1'b1);
    cur_req = "R6";
    core_wfi = 1; tick();
    check("R6", "wfi during flush", pd_req, 1'b0);
    check("R6", "still flushing", flush_req, 1'b1);
    flush_done = 1; tick(); flush_done = 0;
    check("R5", "flush drops on done", flush_req, 1'b0);
    tick();
    check("R6", "pd after wfi", pd_req, 1'b1);
    cur_req = "R7";
    check("R7", "clk off in pd", core_clk_en, 1'b0);
    cur_req = "R10";
    irq_vec = 4'b0100; tick(); irq_vec = '0;
    check("R10", "irq ignored in pd", pd_req, 1'b1);
    tick();
    check("R7", "pd held", pd_req, 1'b1);
    cur_req = "R7";
    pd_ack = 1; tick(); pd_ack = 0;
    check("R7", "pd drops on ack", pd_req, 1'b0);
    check("R7", "clk off when off", core_clk_en, 1'b0);
    cur_req = "R9";
    tick();
    check("R9", "off no pu", pu_req, 1'b0);
    snoop_req = 1; tick(); snoop_req = 0;
    check("R9", "snoop powers up", pu_req, 1'b1);
    tick();
    check("R9", "pu held", pu_req, 1'b1);
    check("R9", "clk off in pu", core_clk_en, 1'b0);
    core_wfi = 0;
    pu_ack = 1; tick(); pu_ack = 0;
    check("R9", "pu drops", pu_req, 1'b0);
    check("R9", "clk back", core_clk_en, 1'b1);

    cur_req = "R2";
    core_wfi = 1; tick();
    check("R2", "wfi gates", core_clk_en, 1'b0);
    cur_req = "R3";
    core_wfi = 0; tick(); tick();
    check("R3", "gate sticky", core_clk_en, 1'b0);
    pwr_ctl_en = 1; pwr_flush_cmd = 1; tick();
    check("R4", "no start while gated", flush_req, 1'b0);
    pwr_ctl_en = 0; pwr_flush_cmd = 0;
    irq_vec = 4'b1000; tick(); irq_vec = '0;
    check("R3", "irq ungates", core_clk_en, 1'b1);
    core_wfi = 1; tick();
    check("R2", "regate", core_clk_en, 1'b0);
    snoop_req = 1; tick(); snoop_req = 0;
    check("R3", "snoop ungates", core_clk_en, 1'b1);
    core_wfi = 0; tick();

    cur_req = "R8";
    pwr_ctl_en = 1; pwr_flush_cmd = 1; tick(); pwr_ctl_en = 0; pwr_flush_cmd = 0;
    check("R8", "restart flush", flush_req, 1'b1);
    snoop_req = 1; tick(); snoop_req = 0;
    check("R8", "snoop no abort", flush_req, 1'b1);
    irq_vec = 4'b0001; tick(); irq_vec = '0;
    check("R8", "irq aborts flush", flush_req, 1'b0);
    check("R8", "clk on after abort", core_clk_en, 1'b1);
    pwr_ctl_en = 1; pwr_flush_cmd = 1; tick(); pwr_ctl_en = 0; pwr_flush_cmd = 0;
    flush_done = 1; tick(); flush_done = 0;
    irq_vec = 4'b0010; tick(); irq_vec = '0;
    check("R8", "abort in wfi wait", pd_req, 1'b0);
    core_wfi = 1; tick();
    check("R8", "no pd after abort", pd_req, 1'b0);
    check("R2", "gates after abort", core_clk_en, 1'b0);
    core_wfi = 0; snoop_req = 1; tick(); snoop_req = 0;
    tick(); tick();

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule